// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block decides whether the on-chip flash may enter program mode or erase mode. Software uses a small register bus to set an enable bit, erase-block selections and a mode request. The block turns an accepted request into a program-active or erase-active level for the flash array. Protection has three independent sources. Hardware protection comes from the write-enable pin going low, standby entry, or any reset. Software protection comes from the enable bit, the RAM-select bit and the erase-block selections. Error protection is a sticky flag raised by an external error input.

Hardware sources do more than mask the request. They clear the control and erase-block registers, and they end a program or erase already running in the same cycle. Software protection refuses a request that is written while it applies. If it takes effect later, it ends the current mode. The error flag stays set until an external reset or a watchdog reset. The external reset asserts at once and is released through a two-flop synchronizer.

Register map (8-bit data, 3-bit address): 0 = control 1 (bit 0 program request, bit 1 erase request, bit 7 software enable), 1 = control 2 (general 8-bit), 2 = erase-block A, 3 = erase-block B, 4 = RAM emulation (bit 3 RAM select). All other addresses read 0.

Top module: `flash_prot_ctrl`

## Requirements
- R1: rstExtN low clears every register and the error flag at once, without waiting for a clock. After rstExtN rises, a bus write presented at the first rising clock edge is ignored. Writes are accepted from the third edge on.
- R2: While wrEnPin is low, progActive and eraseActive are 0 in that same cycle. The next edge clears control 1, control 2 and both erase-block registers. The RAM emulation register keeps its value. Bus writes are ignored while wrEnPin is low.
- R3: A standbyReq pulse has the same effect as a low wrEnPin: it clears the same four registers, keeps the RAM emulation register, and stops the active outputs.
- R4: A wdtRst pulse clears all five registers and the error flag.
- R5: Writing control 1 with bit 0 = 1, bit 1 = 0 and bit 7 = 1 sets progActive from the next cycle, and control 1 then reads back bit 0 = 1. This needs RAM select = 0, no error flag and no hardware protection.
- R6: Writing control 1 with bit 1 = 1, bit 0 = 0 and bit 7 = 1 sets eraseActive from the next cycle, and control 1 then reads back bit 1 = 1. This needs the same conditions as R5, plus at least one bit set across erase-block A and B.
- R7: A request written with bit 7 = 0, or while RAM select = 1, enters neither mode. If RAM select becomes 1 during a mode, the active output drops in the cycle after the write, and the mode does not resume when RAM select is cleared.
- R8: An erase request is refused when both erase-block registers are 0. Clearing them during an erase drops eraseActive in the cycle after the write, and the erase does not resume.
- R9: A control 1 write with both bit 0 and bit 1 set enters neither mode, and progActive and eraseActive are never 1 together.
- R10: errIn high at a clock edge sets errProt and ends any mode. Later requests are refused. Toggling wrEnPin does not clear the flag; only R1 or R4 does.
- R11: hwProt = (wrEnPin low) or standbyReq or wdtRst, and swProt = (bit 7 of control 1 is 0) or (RAM select is 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstExtN | input | 1 | External reset, active low, asynchronous |
| wdtRst | input | 1 | Watchdog reset pulse, synchronous |
| standbyReq | input | 1 | Standby entry request |
| wrEnPin | input | 1 | Flash write-enable pin; low protects |
| errIn | input | 1 | Error event, sets the sticky flag |
| busSel | input | 1 | Register bus select |
| busWe | input | 1 | Register bus write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| progActive | output | 1 | Program mode active |
| eraseActive | output | 1 | Erase mode active |
| hwProt | output | 1 | Hardware protection in force |
| swProt | output | 1 | Software protection in force |
| errProt | output | 1 | Error protection flag |

## Verification
The hardest situations to reach are the ones where a protection source appears while a mode is already running. The stimulus first opens every gate: it sets the enable bit, clears RAM select and selects blocks. It then enters program or erase mode and only afterwards raises the pin, standby, the error input, RAM select, or empty block selections. Each case then checks that the mode stays off after the cause is removed. A full sweep over enable, RAM select, block pattern and request bits compares both active outputs and the read-back request bits with values the bench computes from the gating rules.

// File: rtl/fpc_pkg.sv
`timescale 1ns/1ps
package fpc_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int NUM_BLK  = 2;
  localparam int SYNC_LEN = 2;

  // register addresses
  localparam int A_CTL1   = 0;
  localparam int A_CTL2   = 1;
  localparam int BLK_BASE = 2;
  localparam int A_RAME   = BLK_BASE + NUM_BLK;

  // bit positions
  localparam int P_POS      = 0;
  localparam int E_POS      = 1;
  localparam int SWE_POS    = 7;
  localparam int RAMSEL_POS = 3;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_PROG  = 2'd1,
    MODE_ERASE = 2'd2
  } mode_e;

  typedef struct packed {
    logic wipeCtl;   // clear control and block-select registers
    logic wipeAll;   // also clear the RAM emulation register
    logic wrAllow;   // bus writes permitted
    logic modeP;     // program mode, for read-back
    logic modeE;     // erase mode, for read-back
  } strobe_t;
endpackage

// File: rtl/fpc_rst_sync.sv
`timescale 1ns/1ps
module fpc_rst_sync #(
  parameter int STAGES = fpc_pkg::SYNC_LEN
) (
  input  logic clk,
  input  logic rstAsyncN,
  output logic rstN
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) chain <= '0;
    else            chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rstN = chain[STAGES-1];
endmodule

// File: rtl/fpc_regfile.sv
`timescale 1ns/1ps
module fpc_regfile import fpc_pkg::*; #(
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W,
  parameter int NBK = NUM_BLK
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic          busSel,
  input  logic          busWe,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  output logic          swEnable,
  output logic          ramSelect,
  output logic          blkAny,
  output logic          ctl1Wr,
  output logic          reqP,
  output logic          reqE,
  output logic          reqSwEn
);
  localparam logic [AW-1:0] ADDR_CTL1 = AW'(A_CTL1);
  localparam logic [AW-1:0] ADDR_CTL2 = AW'(A_CTL2);
  localparam logic [AW-1:0] ADDR_RAME = AW'(BLK_BASE + NBK);

  logic          wrHit;
  logic          swEnQ;
  logic [DW-1:0] ctl2Q;
  logic [DW-1:0] ramEmuQ;
  logic [NBK-1:0][DW-1:0] blkQ;

  assign wrHit = busSel && busWe && stb.wrAllow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swEnQ <= 1'b0;
      ctl2Q <= '0;
    end else if (stb.wipeCtl) begin
      swEnQ <= 1'b0;
      ctl2Q <= '0;
    end else if (wrHit) begin
      if (busAddr == ADDR_CTL1) swEnQ <= busWdata[SWE_POS];
      if (busAddr == ADDR_CTL2) ctl2Q <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkQ <= '0;
    end else if (stb.wipeCtl) begin
      blkQ <= '0;
    end else if (wrHit) begin
      for (int i = 0; i < NBK; i++) begin
        if (busAddr == AW'(BLK_BASE + i)) blkQ[i] <= busWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               ramEmuQ <= '0;
    else if (stb.wipeAll)                    ramEmuQ <= '0;
    else if (wrHit && busAddr == ADDR_RAME)  ramEmuQ <= busWdata;
  end

  always_comb begin
    blkAny = 1'b0;
    for (int i = 0; i < NBK; i++) blkAny = blkAny | (|blkQ[i]);
  end

  always_comb begin
    busRdata = '0;
    if (busSel) begin
      if (busAddr == ADDR_CTL1) begin
        busRdata[SWE_POS] = swEnQ;
        busRdata[P_POS]   = stb.modeP;
        busRdata[E_POS]   = stb.modeE;
      end
      if (busAddr == ADDR_CTL2) busRdata = ctl2Q;
      if (busAddr == ADDR_RAME) busRdata = ramEmuQ;
      for (int i = 0; i < NBK; i++) begin
        if (busAddr == AW'(BLK_BASE + i)) busRdata = blkQ[i];
      end
    end
  end

  assign swEnable  = swEnQ;
  assign ramSelect = ramEmuQ[RAMSEL_POS];
  assign ctl1Wr    = wrHit && (busAddr == ADDR_CTL1);
  assign reqP      = busWdata[P_POS];
  assign reqE      = busWdata[E_POS];
  assign reqSwEn   = busWdata[SWE_POS];
endmodule

// File: rtl/fpc_mode_ctrl.sv
`timescale 1ns/1ps
module fpc_mode_ctrl import fpc_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    wdtRst,
  input  logic    standbyReq,
  input  logic    wrEnPin,
  input  logic    errIn,
  input  logic    ctl1Wr,
  input  logic    reqP,
  input  logic    reqE,
  input  logic    reqSwEn,
  input  logic    swEnable,
  input  logic    ramSelect,
  input  logic    blkAny,
  output strobe_t stb,
  output logic    progActive,
  output logic    eraseActive,
  output logic    hwProt,
  output logic    swProt,
  output logic    errProt
);
  mode_e modeQ, modeD;
  logic  errQ;
  logic  progOk, eraseOk;

  assign hwProt = !wrEnPin || standbyReq || wdtRst;
  assign swProt = !swEnable || ramSelect;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       errQ <= 1'b0;
    else if (wdtRst) errQ <= 1'b0;
    else if (errIn)  errQ <= 1'b1;
  end

  // acceptance of a request written to control 1 this cycle
  assign progOk  = reqP && !reqE && reqSwEn && !ramSelect;
  assign eraseOk = reqE && !reqP && reqSwEn && !ramSelect && blkAny;

  always_comb begin
    modeD = modeQ;
    if (ctl1Wr) begin
      if (progOk)       modeD = MODE_PROG;
      else if (eraseOk) modeD = MODE_ERASE;
      else              modeD = MODE_IDLE;
    end else begin
      if (swProt)                          modeD = MODE_IDLE;
      if (modeQ == MODE_ERASE && !blkAny)  modeD = MODE_IDLE;
    end
    if (hwProt || errQ || errIn) modeD = MODE_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_IDLE;
    else       modeQ <= modeD;
  end

  // outputs are vetoed at once by every live protection source
  assign progActive  = (modeQ == MODE_PROG)  && !hwProt && !swProt && !errQ;
  assign eraseActive = (modeQ == MODE_ERASE) && !hwProt && !swProt && !errQ && blkAny;
  assign errProt     = errQ;

  assign stb.wipeCtl = hwProt;
  assign stb.wipeAll = wdtRst;
  assign stb.wrAllow = !hwProt;
  assign stb.modeP   = (modeQ == MODE_PROG);
  assign stb.modeE   = (modeQ == MODE_ERASE);
endmodule

// File: rtl/flash_prot_ctrl.sv
`timescale 1ns/1ps
module flash_prot_ctrl import fpc_pkg::*; (
  input  logic              clk,
  input  logic              rstExtN,
  input  logic              wdtRst,
  input  logic              standbyReq,
  input  logic              wrEnPin,
  input  logic              errIn,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              progActive,
  output logic              eraseActive,
  output logic              hwProt,
  output logic              swProt,
  output logic              errProt
);
  logic    rstN;
  strobe_t stb;
  logic    swEnable, ramSelect, blkAny;
  logic    ctl1Wr, reqP, reqE, reqSwEn;

  fpc_rst_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rstAsyncN(rstExtN), .rstN(rstN)
  );

  fpc_regfile #(.DW(DATA_W), .AW(ADDR_W), .NBK(NUM_BLK)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb),
    .busSel(busSel), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .swEnable(swEnable), .ramSelect(ramSelect),
    .blkAny(blkAny), .ctl1Wr(ctl1Wr), .reqP(reqP), .reqE(reqE), .reqSwEn(reqSwEn)
  );

  fpc_mode_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wdtRst(wdtRst), .standbyReq(standbyReq),
    .wrEnPin(wrEnPin), .errIn(errIn), .ctl1Wr(ctl1Wr), .reqP(reqP),
    .reqE(reqE), .reqSwEn(reqSwEn), .swEnable(swEnable), .ramSelect(ramSelect),
    .blkAny(blkAny), .stb(stb), .progActive(progActive),
    .eraseActive(eraseActive), .hwProt(hwProt), .swProt(swProt), .errProt(errProt)
  );
endmodule

// File: rtl/flash_prot_ctrl_chk.sv
`timescale 1ns/1ps
module flash_prot_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic wdtRst,
  input logic standbyReq,
  input logic wrEnPin,
  input logic errIn,
  input logic progActive,
  input logic eraseActive,
  input logic errProt,
  input logic swEnable,
  input logic ramSelect,
  input logic blkAny
);
  // R9
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(progActive && eraseActive));

  // R2
  hw_veto_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEnPin || standbyReq) |-> (!progActive && !eraseActive));

  // R2
  pin_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEnPin |=> (!swEnable && !blkAny));

  // R3
  standby_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    standbyReq |=> (!swEnable && !blkAny));

  // R4
  wdt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |=> (!ramSelect && !errProt && !swEnable));

  // R10
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errIn && !wdtRst) |=> errProt);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errProt && !wdtRst) |=> errProt);

  // R7
  ram_veto_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramSelect |-> (!progActive && !eraseActive));

  // R8
  erase_blk_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseActive |-> blkAny);
endmodule

bind flash_prot_ctrl flash_prot_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .wdtRst(wdtRst), .standbyReq(standbyReq),
  .wrEnPin(wrEnPin), .errIn(errIn), .progActive(progActive),
  .eraseActive(eraseActive), .errProt(errProt), .swEnable(swEnable),
  .ramSelect(ramSelect), .blkAny(blkAny)
);

// File: tb/flash_prot_ctrl_bench.sv
`timescale 1ns/1ps
module flash_prot_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstExtN = 1'b0, wdtRst = 1'b0, standbyReq = 1'b0;
  logic       wrEnPin = 1'b1, errIn = 1'b0;
  logic       busSel = 1'b0, busWe = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       progActive, eraseActive, hwProt, swProt, errProt;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [2:0] CTL1 = 3'd0, CTL2 = 3'd1, BLKA = 3'd2, BLKB = 3'd3, RAME = 3'd4;

  always #10 clk = ~clk;   // 50 MHz

  flash_prot_ctrl u_flash_prot_ctrl (
    .clk(clk), .rstExtN(rstExtN), .wdtRst(wdtRst), .standbyReq(standbyReq),
    .wrEnPin(wrEnPin), .errIn(errIn), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .progActive(progActive), .eraseActive(eraseActive), .hwProt(hwProt),
    .swProt(swProt), .errProt(errProt)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic extReset();
    @(negedge clk); rstExtN = 1'b0;
    repeat (2) @(negedge clk);
    rstExtN = 1'b1;
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic startProg();
    wr(RAME, 8'h00); wr(BLKA, 8'h01); wr(CTL1, 8'h81);
  endtask

  initial begin
    logic [7:0] v;
    extReset();

    // R1 reset state
    rd(CTL1, v); check("R1 ctl1 after reset", v, 8'h00);
    rd(CTL2, v); check("R1 ctl2 after reset", v, 8'h00);
    rd(RAME, v); check("R1 rame after reset", v, 8'h00);
    check("R1 prog idle", {7'd0, progActive}, 8'd0);
    check("R11 swProt after reset", {7'd0, swProt}, 8'd1);
    check("R11 hwProt after reset", {7'd0, hwProt}, 8'd0);

    // R5 R6 R7 R8 R9 sweep
    for (int sw = 0; sw < 2; sw++)
      for (int ram = 0; ram < 2; ram++)
        for (int bk = 0; bk < 3; bk++)
          for (int pe = 0; pe < 4; pe++) begin
            logic p, e, eP, eE;
            wr(CTL1, 8'h00);
            wr(RAME, ram[0] ? 8'h08 : 8'h00);
            wr(BLKA, (bk == 1) ? 8'h01 : 8'h00);
            wr(BLKB, (bk == 2) ? 8'h80 : 8'h00);
            wr(CTL1, {sw[0], 5'd0, pe[1:0]});
            p = pe[0]; e = pe[1];
            eP = p && !e && sw[0] && !ram[0];
            eE = e && !p && sw[0] && !ram[0] && (bk != 0);
            check("R5 R9 progActive sweep", {7'd0, progActive}, {7'd0, eP});
            check("R6 R8 eraseActive sweep", {7'd0, eraseActive}, {7'd0, eE});
            rd(CTL1, v);
            check("R7 ctl1 readback sweep", v, {sw[0], 5'd0, eE, eP});
            check("R11 swProt sweep", {7'd0, swProt}, {7'd0, !sw[0] || ram[0]});
          end

    // R8 erase aborted by clearing blocks
    wr(RAME, 8'h00); wr(BLKB, 8'h00); wr(BLKA, 8'h04); wr(CTL1, 8'h82);
    check("R6 erase entered", {7'd0, eraseActive}, 8'd1);
    wr(BLKA, 8'h00);
    check("R8 erase dropped", {7'd0, eraseActive}, 8'd0);
    wr(BLKA, 8'h04);
    check("R8 erase not resumed", {7'd0, eraseActive}, 8'd0);
    rd(CTL1, v); check("R8 ctl1 erase bit cleared", v, 8'h80);

    // R7 RAM select during program
    startProg();
    check("R5 prog entered", {7'd0, progActive}, 8'd1);
    wr(RAME, 8'h08);
    check("R7 prog dropped by ram select", {7'd0, progActive}, 8'd0);
    wr(RAME, 8'h00);
    check("R7 prog not resumed", {7'd0, progActive}, 8'd0);

    // R2 pin protection
    wr(CTL2, 8'h5A); wr(BLKB, 8'h40); startProg(); wr(RAME, 8'h01);
    check("R5 prog before pin", {7'd0, progActive}, 8'd1);
    @(negedge clk); wrEnPin = 1'b0; #1;
    check("R2 prog aborted same cycle", {7'd0, progActive}, 8'd0);
    check("R11 hwProt pin", {7'd0, hwProt}, 8'd1);
    wr(CTL2, 8'hFF);
    @(negedge clk); wrEnPin = 1'b1; #1;
    rd(CTL1, v); check("R2 ctl1 wiped", v, 8'h00);
    rd(CTL2, v); check("R2 ctl2 wiped, write ignored", v, 8'h00);
    rd(BLKA, v); check("R2 blka wiped", v, 8'h00);
    rd(BLKB, v); check("R2 blkb wiped", v, 8'h00);
    rd(RAME, v); check("R2 rame kept", v, 8'h01);
    check("R2 prog stays off", {7'd0, progActive}, 8'd0);

    // R3 standby
    wr(RAME, 8'h00); wr(BLKA, 8'h02); wr(CTL2, 8'h11); wr(CTL1, 8'h82); wr(RAME, 8'h01);
    check("R6 erase before standby", {7'd0, eraseActive}, 8'd1);
    @(negedge clk); standbyReq = 1'b1; #1;
    check("R3 erase aborted", {7'd0, eraseActive}, 8'd0);
    check("R11 hwProt standby", {7'd0, hwProt}, 8'd1);
    @(negedge clk); standbyReq = 1'b0; #1;
    rd(BLKA, v); check("R3 blka wiped", v, 8'h00);
    rd(CTL2, v); check("R3 ctl2 wiped", v, 8'h00);
    rd(RAME, v); check("R3 rame kept", v, 8'h01);

    // R10 error flag
    startProg();
    @(negedge clk); errIn = 1'b1;
    @(negedge clk); errIn = 1'b0; #1;
    check("R10 errProt set", {7'd0, errProt}, 8'd1);
    check("R10 prog ended", {7'd0, progActive}, 8'd0);
    wr(CTL1, 8'h81);
    check("R10 request refused", {7'd0, progActive}, 8'd0);
    @(negedge clk); wrEnPin = 1'b0;
    @(negedge clk); wrEnPin = 1'b1; #1;
    check("R10 pin does not clear", {7'd0, errProt}, 8'd1);

    // R4 watchdog reset
    wr(RAME, 8'h08); wr(CTL2, 8'h22);
    @(negedge clk); wdtRst = 1'b1; #1;
    check("R11 hwProt wdt", {7'd0, hwProt}, 8'd1);
    @(negedge clk); wdtRst = 1'b0; #1;
    check("R4 errProt cleared", {7'd0, errProt}, 8'd0);
    rd(RAME, v); check("R4 rame cleared", v, 8'h00);
    rd(CTL2, v); check("R4 ctl2 cleared", v, 8'h00);
    startProg();
    check("R4 prog allowed after wdt", {7'd0, progActive}, 8'd1);

    // R1 asynchronous clear and synchronized release
    wr(CTL2, 8'h33);
    @(negedge clk); errIn = 1'b1;
    @(negedge clk); errIn = 1'b0;
    #3 rstExtN = 1'b0; #1;
    rd(CTL2, v); check("R1 async clear ctl2", v, 8'h00);
    check("R1 async clear err", {7'd0, errProt}, 8'd0);
    check("R1 async prog off", {7'd0, progActive}, 8'd0);
    @(negedge clk); rstExtN = 1'b1;
    busSel = 1'b1; busWe = 1'b1; busAddr = CTL2; busWdata = 8'h77;
    @(negedge clk); busSel = 1'b0; busWe = 1'b0; #1;
    rd(CTL2, v); check("R1 write at first edge ignored", v, 8'h00);
    @(negedge clk);
    wr(CTL2, 8'h77);
    rd(CTL2, v); check("R1 write after release", v, 8'h77);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule